// File: doc/BRIEF.md
# VLIW Packet Issue Sequencer

This block walks the instruction words of one very-long-instruction-word packet, handing one instruction per step to the execution side, and decides where the packet ends. Each packet begins with a one-cycle opening step. That step clears the commit queue, records the program counter the packet started from, and forgets any floating/media slot tracked for the previous packet. Issue then runs until an instruction carries its end-of-packet marker or the packet reaches its length limit. A one-cycle closing step follows. It fires commit and interrupt processing and adds the packet length to a retired-instruction count.

Instructions arrive on a valid/ready stream and leave on a second valid/ready stream. The word and unit code pass through unchanged. The downstream side may hold `iss_ready` low for any number of cycles. While it does, `ins_ready` stays low, the word offered downstream stays stable and nothing advances. During the opening and closing steps `ins_ready` is low whatever `iss_ready` does. An instruction counts as issued on the clock edge where `iss_valid` and `iss_ready` are both high. The execution side returns the address of the following instruction on `exe_npc` in that same cycle. The block also asks for general register 0 to be written with zero whenever it offers an instruction. It marks the first instruction of each packet for the fetch-penalty logic.

Top module: `vliw_issue_seq`

## Requirements
- R1: A packet-open cycle (`pkt_start` high for one cycle) comes in the first cycle after reset and in the cycle after every `pkt_done`. In that cycle `ins_ready` and `iss_valid` are low. In the following cycle `prev_pc` equals the `cur_pc` of the open cycle and `fm_valid` is 0.
- R2: While issuing, `iss_valid` follows `ins_valid` and `ins_ready` follows `iss_ready`. `iss_word` and `iss_unit` equal `ins_word` and `ins_unit`. During a stall the offered word stays stable and is not consumed.
- R3: An offered instruction whose word has bit 31 set is flagged `iss_last` and closes the packet.
- R4: When the instruction about to be issued is number LIMIT in its packet (default 4), it is flagged `iss_last` and closes the packet even with bit 31 clear. No error is raised.
- R5: `iss_first` is high for the first instruction offered in a packet and low for every later one.
- R6: `gr0_clr` is high in every cycle an instruction is offered (`iss_valid`).
- R7: At issue, unit codes 4, 5, 6 and 7 (media slots 0 to 3) set `fm_valid` to 1 and `fm_idx` to code minus 4 from the next cycle on. Codes 0 to 3 leave `fm_valid` and `fm_idx` unchanged.
- R8: In the cycle after each issue, `cur_pc` equals the `exe_npc` value given with that issue.
- R9: `pkt_done` is high for exactly the one cycle after the issue of a last instruction, and never after any other issue. In that cycle `pkt_len` gives the number of instructions issued in the packet.
- R10: In the cycle after `pkt_done`, `retired` has grown by `pkt_len`.
- R11: Reset gives `retired` = 0, `cur_pc` = `prev_pc` = RESET_PC, `fm_valid` = 0, `pkt_done` = 0. A packet in progress is abandoned without being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Incoming instruction present |
| ins_ready | output | 1 | Incoming instruction consumed this cycle |
| ins_word | input | 32 | Instruction word, bit 31 = end of packet |
| ins_unit | input | 3 | Unit code, 4..7 = media slots 0..3 |
| iss_valid | output | 1 | Instruction offered to execution |
| iss_ready | input | 1 | Execution accepts the offered instruction |
| iss_word | output | 32 | Offered instruction word |
| iss_unit | output | 3 | Offered unit code |
| iss_first | output | 1 | Offered instruction is first of its packet |
| iss_last | output | 1 | Offered instruction is last of its packet |
| exe_npc | input | AW | Next instruction address, valid at issue |
| gr0_clr | output | 1 | Write zero to general register 0 |
| pkt_start | output | 1 | Packet open: clear the commit queue |
| prev_pc | output | AW | Address the current packet started from |
| cur_pc | output | AW | Address after the last issued instruction |
| fm_valid | output | 1 | A media slot has been used in this packet |
| fm_idx | output | 2 | Last media slot used |
| pkt_done | output | 1 | Packet closed: run commit and interrupts |
| pkt_len | output | CW | Instructions issued in the packet |
| retired | output | RW | Running count of retired instructions |

## Verification
A wrong instruction count shows up at the boundary first. `iss_last` rises one instruction early or late, and in the very next cycle `pkt_done` carries a `pkt_len` that does not match the instructions issued. `retired` then stays off by the difference for the rest of the run. A state machine stuck in the opening or closing step shows as `ins_ready` held low with work waiting, or as a second `pkt_start` without a `pkt_done` between them. Stale media-slot or address state appears one cycle after the offending issue on `fm_idx` or `cur_pc`, and a missed clear appears one cycle after `pkt_start`.

// File: rtl/vliw_seq_pkg.sv
package vliw_seq_pkg;
  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_CLOSE = 2'd2
  } seq_state_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PACK_BIT = 31;
  localparam int unsigned UNIT_W   = 3;
  localparam int unsigned SLOT_W   = 2;

  function automatic logic unit_is_media(input logic [UNIT_W-1:0] unit);
    return unit[UNIT_W-1];
  endfunction

  function automatic logic [SLOT_W-1:0] media_slot(input logic [UNIT_W-1:0] unit);
    return unit[SLOT_W-1:0];
  endfunction
endpackage

// File: rtl/vliw_seq_fsm.sv
module vliw_seq_fsm
  import vliw_seq_pkg::*;
#(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic          iss_ready,
  input  logic          pack_bit,
  output logic          open_o,
  output logic          issue_o,
  output logic          close_o,
  output logic          fire_o,
  output logic          first_o,
  output logic          last_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] LAST_IDX = CW'(LIMIT - 1);

  seq_state_e    state_q;
  seq_state_e    state_d;
  logic [CW-1:0] count_q;

  assign open_o  = (state_q == ST_OPEN);
  assign issue_o = (state_q == ST_ISSUE);
  assign close_o = (state_q == ST_CLOSE);
  assign fire_o  = issue_o && ins_valid && iss_ready;
  assign first_o = (count_q == '0);
  assign last_o  = pack_bit || (count_q == LAST_IDX);
  assign count_o = count_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN:  state_d = ST_ISSUE;
      ST_ISSUE: if (fire_o && last_o) state_d = ST_CLOSE;
      ST_CLOSE: state_d = ST_OPEN;
      default:  state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      if (open_o)
        count_q <= '0;
      else if (fire_o)
        count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/vliw_seq_ctx.sv
module vliw_seq_ctx
  import vliw_seq_pkg::*;
#(
  parameter int unsigned       AW       = 32,
  parameter logic [AW-1:0]     RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              fire_i,
  input  logic [AW-1:0]     npc_i,
  input  logic [UNIT_W-1:0] unit_i,
  output logic [AW-1:0]     cur_pc_o,
  output logic [AW-1:0]     prev_pc_o,
  output logic              fm_valid_o,
  output logic [SLOT_W-1:0] fm_idx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pc_o  <= RESET_PC;
      prev_pc_o <= RESET_PC;
    end else begin
      if (open_i) prev_pc_o <= cur_pc_o;
      if (fire_i) cur_pc_o  <= npc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_valid_o <= 1'b0;
      fm_idx_o   <= '0;
    end else if (open_i) begin
      fm_valid_o <= 1'b0;
      fm_idx_o   <= '0;
    end else if (fire_i && unit_is_media(unit_i)) begin
      fm_valid_o <= 1'b1;
      fm_idx_o   <= media_slot(unit_i);
    end
  end
endmodule

// File: rtl/vliw_seq_retire.sv
module vliw_seq_retire #(
  parameter int unsigned CW = 3,
  parameter int unsigned RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          close_i,
  input  logic [CW-1:0] len_i,
  output logic [RW-1:0] retired_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      retired_o <= '0;
    else if (close_i)
      retired_o <= retired_o + RW'(len_i);
  end
endmodule

// File: rtl/vliw_issue_seq.sv
module vliw_issue_seq
  import vliw_seq_pkg::*;
#(
  parameter int unsigned   LIMIT    = 4,
  parameter int unsigned   AW       = 32,
  parameter int unsigned   RW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter int unsigned   CW       = $clog2(LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [31:0]       ins_word,
  input  logic [2:0]        ins_unit,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [31:0]       iss_word,
  output logic [2:0]        iss_unit,
  output logic              iss_first,
  output logic              iss_last,
  input  logic [AW-1:0]     exe_npc,
  output logic              gr0_clr,
  output logic              pkt_start,
  output logic [AW-1:0]     prev_pc,
  output logic [AW-1:0]     cur_pc,
  output logic              fm_valid,
  output logic [1:0]        fm_idx,
  output logic              pkt_done,
  output logic [CW-1:0]     pkt_len,
  output logic [RW-1:0]     retired
);
  logic          open_w;
  logic          issue_w;
  logic          close_w;
  logic          fire_w;
  logic          first_w;
  logic          last_w;
  logic [CW-1:0] count_w;

  vliw_seq_fsm #(.LIMIT(LIMIT), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .iss_ready (iss_ready),
    .pack_bit  (ins_word[PACK_BIT]),
    .open_o    (open_w),
    .issue_o   (issue_w),
    .close_o   (close_w),
    .fire_o    (fire_w),
    .first_o   (first_w),
    .last_o    (last_w),
    .count_o   (count_w)
  );

  vliw_seq_ctx #(.AW(AW), .RESET_PC(RESET_PC)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (open_w),
    .fire_i     (fire_w),
    .npc_i      (exe_npc),
    .unit_i     (ins_unit),
    .cur_pc_o   (cur_pc),
    .prev_pc_o  (prev_pc),
    .fm_valid_o (fm_valid),
    .fm_idx_o   (fm_idx)
  );

  vliw_seq_retire #(.CW(CW), .RW(RW)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .close_i   (close_w),
    .len_i     (count_w),
    .retired_o (retired)
  );

  assign iss_valid = issue_w && ins_valid;
  assign ins_ready = issue_w && iss_ready;
  assign iss_word  = ins_word;
  assign iss_unit  = ins_unit;
  assign iss_first = first_w;
  assign iss_last  = last_w;
  assign gr0_clr   = iss_valid;
  assign pkt_start = open_w;
  assign pkt_done  = close_w;
  assign pkt_len   = count_w;
endmodule

// File: rtl/vliw_issue_seq_chk.sv
module vliw_issue_seq_chk #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned RW    = 32,
  parameter int unsigned CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic          ins_ready,
  input logic          iss_last,
  input logic          gr0_clr,
  input logic          pkt_start,
  input logic          pkt_done,
  input logic [CW-1:0] pkt_len,
  input logic [AW-1:0] exe_npc,
  input logic [AW-1:0] cur_pc,
  input logic [AW-1:0] prev_pc,
  input logic          fm_valid,
  input logic [RW-1:0] retired
);
  // R6
  gr0_follows_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> gr0_clr);

  // R1
  open_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> pkt_start);

  // R1
  open_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (!ins_ready && !iss_valid));

  // R1
  open_clears_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (!fm_valid && prev_pc == $past(cur_pc)));

  // R9
  close_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_last) |=> pkt_done);

  // R9
  no_close_midpacket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !iss_last) |=> !pkt_done);

  // R4
  len_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len >= CW'(1) && pkt_len <= CW'(LIMIT)));

  // R10
  retired_adds_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> (retired == $past(retired) + RW'($past(pkt_len))));

  // R8
  pc_tracks_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> (cur_pc == $past(exe_npc)));
endmodule

bind vliw_issue_seq vliw_issue_seq_chk #(
  .LIMIT(LIMIT), .AW(AW), .RW(RW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .ins_ready (ins_ready),
  .iss_last  (iss_last),
  .gr0_clr   (gr0_clr),
  .pkt_start (pkt_start),
  .pkt_done  (pkt_done),
  .pkt_len   (pkt_len),
  .exe_npc   (exe_npc),
  .cur_pc    (cur_pc),
  .prev_pc   (prev_pc),
  .fm_valid  (fm_valid),
  .retired   (retired)
);

// File: tb/vliw_issue_seq_tb.sv
module vliw_issue_seq_tb;
  localparam int unsigned LIMIT = 4;
  localparam int unsigned AW    = 32;
  localparam int unsigned RW    = 32;
  localparam int unsigned CW    = $clog2(LIMIT + 1);
  localparam logic [AW-1:0] RST_PC = 32'h0000_1000;
  localparam int NV = 14;

  // entry: {pack[37], unit[36:34], npc[33:2], stall[1:0]}
  localparam logic [37:0] TBL [NV] = '{
    {1'b0, 3'd1, 32'h0000_1004, 2'd0},
    {1'b0, 3'd5, 32'h0000_1008, 2'd1},
    {1'b1, 3'd2, 32'h0000_100C, 2'd0},
    {1'b0, 3'd4, 32'h0000_1010, 2'd0},
    {1'b0, 3'd7, 32'h0000_1014, 2'd2},
    {1'b0, 3'd0, 32'h0000_1018, 2'd0},
    {1'b0, 3'd3, 32'h0000_101C, 2'd0},
    {1'b1, 3'd6, 32'h0000_2000, 2'd0},
    {1'b0, 3'd0, 32'h0000_2004, 2'd0},
    {1'b0, 3'd1, 32'h0000_2008, 2'd0},
    {1'b0, 3'd2, 32'h0000_200C, 2'd3},
    {1'b1, 3'd3, 32'h0000_2010, 2'd0},
    {1'b0, 3'd0, 32'h0000_2014, 2'd0},
    {1'b1, 3'd1, 32'h0000_3000, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [31:0] ins_word = '0;
  logic [2:0] ins_unit = '0;
  logic iss_ready = 1'b0;
  logic [AW-1:0] exe_npc = '0;
  logic ins_ready, iss_valid, iss_first, iss_last, gr0_clr;
  logic pkt_start, pkt_done, fm_valid;
  logic [31:0] iss_word;
  logic [2:0] iss_unit;
  logic [AW-1:0] prev_pc, cur_pc;
  logic [1:0] fm_idx;
  logic [CW-1:0] pkt_len;
  logic [RW-1:0] retired;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vliw_issue_seq #(.LIMIT(LIMIT), .AW(AW), .RW(RW), .RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_unit(ins_unit), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_word(iss_word), .iss_unit(iss_unit),
    .iss_first(iss_first), .iss_last(iss_last), .exe_npc(exe_npc),
    .gr0_clr(gr0_clr), .pkt_start(pkt_start), .prev_pc(prev_pc),
    .cur_pc(cur_pc), .fm_valid(fm_valid), .fm_idx(fm_idx),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .retired(retired)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt = 0;
    logic [RW-1:0] ret_exp = '0;
    logic fmv_exp = 1'b0;
    logic [1:0] fmi_exp = '0;

    // R11: reset values
    repeat (2) @(negedge clk);
    #1;
    chk(retired == 0, "R11 retired", retired, 0);
    chk(cur_pc == RST_PC && prev_pc == RST_PC, "R11 pc", cur_pc, RST_PC);
    chk(!fm_valid && !pkt_done, "R11 fm/done", {fm_valid, pkt_done}, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(pkt_start == 1'b1, "R1 open after reset", pkt_start, 1);

    for (int i = 0; i < NV; i++) begin
      logic pk;
      logic [2:0] un;
      logic [31:0] np;
      int st;
      logic exp_last;
      pk = TBL[i][37]; un = TBL[i][36:34]; np = TBL[i][33:2]; st = int'(TBL[i][1:0]);
      ins_valid = 1'b1;
      ins_word  = {pk, 31'(i * 3 + 1)};
      ins_unit  = un;
      exe_npc   = np;
      iss_ready = (st == 0);
      #1;
      while (!iss_valid) begin
        chk(!ins_ready, "R1 no accept outside issue", ins_ready, 0);
        @(negedge clk); #1;
      end
      exp_last = pk || (cnt == LIMIT - 1);
      chk(iss_first == (cnt == 0), "R5 first flag", iss_first, cnt == 0);
      chk(iss_last == exp_last, pk ? "R3 pack bit last" : "R4 limit last", iss_last, exp_last);
      chk(gr0_clr, "R6 gr0 clear", gr0_clr, 1);
      chk(iss_word == ins_word && iss_unit == un, "R2 pass-through", iss_word, ins_word);
      for (int s = 0; s < st; s++) begin
        chk(!ins_ready, "R2 stall holds", ins_ready, 0);
        @(negedge clk); #1;
        chk(iss_valid && iss_word == ins_word, "R2 stall stable", iss_word, ins_word);
      end
      iss_ready = 1'b1; #1;
      chk(ins_ready, "R2 ready follows", ins_ready, 1);
      @(negedge clk);
      ins_valid = 1'b0;
      #1;
      cnt++;
      if (un[2]) begin fmv_exp = 1'b1; fmi_exp = un[1:0]; end
      chk(cur_pc == np, "R8 pc update", cur_pc, np);
      chk(fm_valid == fmv_exp && fm_idx == fmi_exp, "R7 media slot", {fm_valid, fm_idx}, {fmv_exp, fmi_exp});
      if (exp_last) begin
        chk(pkt_done && pkt_len == CW'(cnt), "R9 close and length", pkt_len, cnt);
        ret_exp = ret_exp + RW'(cnt);
        @(negedge clk); #1;
        chk(pkt_start, "R1 reopen", pkt_start, 1);
        chk(!pkt_done, "R9 single done", pkt_done, 0);
        chk(retired == ret_exp, "R10 retired", retired, ret_exp);
        @(negedge clk); #1;
        chk(prev_pc == np && !fm_valid, "R1 open latch", prev_pc, np);
        cnt = 0; fmv_exp = 1'b0; fmi_exp = '0;
      end else begin
        chk(!pkt_done, "R9 no early close", pkt_done, 0);
      end
    end

    // R2: idle input offers nothing, and R6 gr0 clear stays low
    @(negedge clk); #1;
    chk(!iss_valid && !gr0_clr, "R2 idle no offer", iss_valid, 0);
    chk(!pkt_done, "R9 idle", pkt_done, 0);

    // R11: reset in the middle of a packet
    ins_valid = 1'b1; ins_word = 32'h0000_0055; ins_unit = 3'd6;
    exe_npc = 32'h0000_4444; iss_ready = 1'b1;
    @(negedge clk); ins_valid = 1'b0; #1;
    chk(cur_pc == 32'h0000_4444 && fm_valid, "R7 pre-reset issue", cur_pc, 32'h4444);
    rst_n = 1'b0; #1;
    chk(retired == 0 && cur_pc == RST_PC && !fm_valid, "R11 mid-packet reset", retired, 0);
    chk(prev_pc == RST_PC && !pkt_done, "R11 prev_pc", prev_pc, RST_PC);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(pkt_start, "R1 open after mid reset", pkt_start, 1);
    @(negedge clk); #1;
    chk(!pkt_start && retired == 0, "R11 no count kept", retired, 0);

    finish_run();
  end
endmodule